// File: doc/BRIEF.md
# Self-Synchronizing PRBS Bit Error Detector

This block sits behind a demodulator under test and judges every received bit against a locally regenerated pseudorandom sequence. The sequence comes from the polynomial x^15 + x^14 + 1, which the transmitter must also use. The reference lives in a 15-bit shift register. While the demodulator reports that it is not locked, the register loads the incoming bits. After at least fifteen such bits of a clean stream, the register holds the transmitter's state.

When lock is reported, a multiplexer switches the register input to its own feedback bit. From then on, every bit time where the received bit differs from the generated bit is an error. The error and bit-time indications come out as return-to-zero pulses: high for the first half of the clock period and low for the second. An external pulse counter therefore sees back-to-back errors as separate pulses.

A wrongly seeded register gives an error ratio near one half. The block detects this case with a windowed error count and raises a sync-lost flag, so the operator can restart the measurement.

Top module: `prbs_err_detector`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the reference register clears, and `err_pulse`, `bit_pulse` and `sync_lost` are low after that edge.
- R2: On a rising edge with `lock_in` low, the reference register shifts in `rx_bit` (new bit at the low end), and `err_pulse` stays low for the following clock period.
- R3: On a rising edge with `lock_in` high, the generated bit is register bit 14 XOR bit 13. That bit shifts in at the low end, and an error is flagged for the following period exactly when `rx_bit` differs from it.
- R4: `err_pulse` is the error flag ANDed with the high clock phase. It is low throughout every low clock phase, so two consecutive errors produce two distinct pulses.
- R5: `bit_pulse` is high during the high phase of the period that follows every rising edge with `lock_in` high. It is low otherwise and low in every low clock phase.
- R6: Locked bit times are grouped into windows of 1024, and the first window starts at the first locked edge after `lock_in` was low. `sync_lost` is raised on the edge that counts the 257th error inside a window. Exactly 256 errors in a window leave it low.
- R7: Once raised, `sync_lost` stays high while `lock_in` stays high, even across window boundaries. It clears on the first rising edge with `lock_in` low, which also restarts the window and error count.
- R8: A received bit flipped while locked yields exactly one error and does not disturb the reference, so later clean bits produce no error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Data clock, 50 % duty; rising edge samples data |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_bit | input | 1 | Received serial data bit |
| lock_in | input | 1 | Demodulator lock indication, high when locked |
| err_pulse | output | 1 | Return-to-zero pulse per mismatched locked bit |
| bit_pulse | output | 1 | Return-to-zero pulse per locked bit time |
| sync_lost | output | 1 | High when the windowed error count shows a mis-seeded reference |

## Verification
The detector is tried with several input patterns:
- A clean stream seeded while unlocked and then locked shows that self-synchronization works, because it yields no errors at all.
- Isolated, paired and tripled bit flips show that each flip gives exactly one pulse, that back-to-back errors return to zero in between, and that the reference does not follow the corrupted data.
- A stream with flipped bits while unlocked, followed by a clean reseed, separates "loaded but not judged" from "judged".
- Windows with exactly 256 and then 257 errors probe the threshold edge and the stickiness across a window boundary.
- A register seeded with zeros before lock produces the near-one-half error ratio that must trip the sync-lost flag.

// File: rtl/prbs_det_pkg.sv
// Package: shared constants and helpers for the PRBS error detector.
// Assumes Fibonacci-form generators that shift toward the high bit index.
package prbs_det_pkg;

    // Default reference length and tap positions for x^15 + x^14 + 1
    localparam int PRBS_LEN   = 15;
    localparam int PRBS_TAP_A = 14;
    localparam int PRBS_TAP_B = 13;

    // Default sync-loss window and threshold
    localparam int SYNC_WINDOW = 1024;
    localparam int SYNC_LIMIT  = 256;

    // Width that can hold values 0..max
    function automatic int cnt_width(input int max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/prbs_ref_gen.sv
// Module: prbs_ref_gen
// Holds the reference pseudorandom register. While unlocked it loads the
// received bits; while locked it runs on its own two-tap feedback and
// compares each received bit to the generated one.
// Assumes: lock_in and rx_data are stable around the rising clock edge.
module prbs_ref_gen #(
    parameter int LEN   = prbs_det_pkg::PRBS_LEN,
    parameter int TAP_A = prbs_det_pkg::PRBS_TAP_A,
    parameter int TAP_B = prbs_det_pkg::PRBS_TAP_B
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lock_in,
    input  logic rx_data,
    output logic mismatch,
    output logic err_flag
);

    logic [LEN-1:0] sr_q;
    logic           gen_bit;
    logic           shift_in;

    // Feedback bit predicted from the current register contents
    assign gen_bit  = sr_q[TAP_A] ^ sr_q[TAP_B];

    // Lock-controlled multiplexer: seed from line or free-run
    assign shift_in = lock_in ? gen_bit : rx_data;

    // Comparison is only meaningful while locked
    assign mismatch = lock_in & (rx_data ^ gen_bit);

    // Shift the reference register and capture the error flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q     <= '0;
            err_flag <= 1'b0;
        end else begin
            sr_q     <= {sr_q[LEN-2:0], shift_in};
            err_flag <= mismatch;
        end
    end

    AST_UNLOCKED_LOADS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_in |=> (sr_q[0] == $past(rx_data))); // R2

    AST_UNLOCKED_NO_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_in |=> !err_flag); // R2

endmodule

// File: rtl/sync_window_mon.sv
// Module: sync_window_mon
// Counts errors over fixed windows of locked bit times. Raises a sticky
// flag when a window collects more than LIMIT errors. Loss of lock clears
// both the flag and the window.
// Assumes: err_hit is already gated by lock.
module sync_window_mon #(
    parameter int WIN   = prbs_det_pkg::SYNC_WINDOW,
    parameter int LIMIT = prbs_det_pkg::SYNC_LIMIT
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lock_in,
    input  logic err_hit,
    output logic sync_lost
);

    localparam int CW = prbs_det_pkg::cnt_width(WIN);

    logic [CW-1:0] bit_cnt_q;
    logic [CW-1:0] err_cnt_q;
    logic [CW-1:0] err_next;
    logic          win_last;

    // Error total including the current bit time
    assign err_next = err_cnt_q + CW'(err_hit);
    assign win_last = (bit_cnt_q == CW'(WIN - 1));

    // Window and error counters, restarted on loss of lock or window end
    always_ff @(posedge clk) begin
        if (!rst_n || !lock_in) begin
            bit_cnt_q <= '0;
            err_cnt_q <= '0;
        end else if (win_last) begin
            bit_cnt_q <= '0;
            err_cnt_q <= '0;
        end else begin
            bit_cnt_q <= bit_cnt_q + 1'b1;
            err_cnt_q <= err_next;
        end
    end

    // Sticky sync-lost flag, cleared only while unlocked
    always_ff @(posedge clk) begin
        if (!rst_n || !lock_in) begin
            sync_lost <= 1'b0;
        end else if (err_next > CW'(LIMIT)) begin
            sync_lost <= 1'b1;
        end
    end

    AST_ERRORS_WITHIN_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        err_cnt_q <= bit_cnt_q); // R6

    AST_SYNC_RISES_ON_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_lost) |-> $past(err_hit)); // R6

    AST_SYNC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_lost && lock_in) |=> sync_lost); // R7

endmodule

// File: rtl/rz_shaper.sv
// Module: rz_shaper
// Turns a registered level into a return-to-zero pulse by ANDing it with
// the high clock phase. The pulse width is half the clock period.
// Assumes: a 50 % duty clock and a level that changes only on rising edges.
module rz_shaper (
    input  logic clk,
    input  logic level,
    output logic pulse
);

    // Gate the level with the clock so the pulse returns to zero each period
    assign pulse = level & clk;

endmodule

// File: rtl/prbs_err_detector.sv
// Module: prbs_err_detector (top)
// Self-synchronizing PRBS error detector: reference generator, windowed
// sync monitor and return-to-zero shaping of the error and bit pulses.
// Assumes: the transmitter uses the same polynomial, and the data clock
// has a 50 % duty cycle.
module prbs_err_detector #(
    parameter int LEN   = prbs_det_pkg::PRBS_LEN,
    parameter int TAP_A = prbs_det_pkg::PRBS_TAP_A,
    parameter int TAP_B = prbs_det_pkg::PRBS_TAP_B,
    parameter int WIN   = prbs_det_pkg::SYNC_WINDOW,
    parameter int LIMIT = prbs_det_pkg::SYNC_LIMIT
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_bit,
    input  logic lock_in,
    output logic err_pulse,
    output logic bit_pulse,
    output logic sync_lost
);

    logic mismatch;
    logic err_flag;
    logic bit_flag;

    prbs_ref_gen #(
        .LEN   (LEN),
        .TAP_A (TAP_A),
        .TAP_B (TAP_B)
    ) u_ref (
        .clk      (clk),
        .rst_n    (rst_n),
        .lock_in  (lock_in),
        .rx_data  (rx_bit),
        .mismatch (mismatch),
        .err_flag (err_flag)
    );

    sync_window_mon #(
        .WIN   (WIN),
        .LIMIT (LIMIT)
    ) u_mon (
        .clk       (clk),
        .rst_n     (rst_n),
        .lock_in   (lock_in),
        .err_hit   (mismatch),
        .sync_lost (sync_lost)
    );

    // Mark each locked bit time for the bit-count pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_flag <= 1'b0;
        end else begin
            bit_flag <= lock_in;
        end
    end

    rz_shaper u_err_rz (
        .clk   (clk),
        .level (err_flag),
        .pulse (err_pulse)
    );

    rz_shaper u_bit_rz (
        .clk   (clk),
        .level (bit_flag),
        .pulse (bit_pulse)
    );

    AST_BIT_MARKS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        lock_in |=> bit_flag); // R5

    AST_BIT_QUIET_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_in |=> !bit_flag); // R5

    AST_SYNC_CLEARS_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_in |=> !sync_lost); // R7

endmodule

// File: tb/tb_prbs_err_detector.sv
`timescale 1ns/1ps
module tb_prbs_err_detector;

    localparam real HALF = 2.0;   // 250 MHz clock
    localparam int  WD_CYCLES = 200000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_bit = 1'b0;
    logic lock_in = 1'b0;
    logic err_pulse, bit_pulse, sync_lost;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Expected {err, bit, sync} per rising edge
    logic [2:0] exp_q[$];

    // Transmitter model and requirement-derived reference model
    logic [14:0] tx_s = 15'h5A3C;
    logic [14:0] m_ref = '0;
    int          m_bits = 0;
    int          m_errs = 0;
    logic        m_sync = 1'b0;

    always #(HALF) clk = ~clk;

    prbs_err_detector dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_bit    (rx_bit),
        .lock_in   (lock_in),
        .err_pulse (err_pulse),
        .bit_pulse (bit_pulse),
        .sync_lost (sync_lost)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic next_tx(output logic b);
        b    = tx_s[14] ^ tx_s[13];
        tx_s = {tx_s[13:0], b};
    endtask

    // Driver: apply one bit at the falling edge and push the expectation
    task automatic drive_bit(input logic rx, input logic lk);
        logic g, e;
        @(negedge clk);
        rx_bit  = rx;
        lock_in = lk;
        g = m_ref[14] ^ m_ref[13];
        if (lk) begin
            e     = rx ^ g;
            m_ref = {m_ref[13:0], g};
            if (m_errs + int'(e) > 256) m_sync = 1'b1;
            if (m_bits == 1023) begin
                m_bits = 0;
                m_errs = 0;
            end else begin
                m_bits++;
                m_errs = m_errs + int'(e);
            end
        end else begin
            e      = 1'b0;
            m_ref  = {m_ref[13:0], rx};
            m_bits = 0;
            m_errs = 0;
            m_sync = 1'b0;
        end
        exp_q.push_back({e, lk, m_sync});
    endtask

    // Send n transmitter bits, flipping those whose index is in [f_lo, f_hi)
    task automatic send_run(input int n, input logic lk, input int f_lo, input int f_hi);
        logic b;
        for (int i = 0; i < n; i++) begin
            next_tx(b);
            drive_bit(b ^ ((i >= f_lo) && (i < f_hi)), lk);
        end
    endtask

    // Monitor: compare high-phase outputs with the scoreboard
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic [2:0] x;
                x = exp_q.pop_front();
                check(x[1] ? "R3 R8 err_pulse" : "R2 err_pulse", err_pulse, x[2]);
                check("R5 bit_pulse", bit_pulse, x[1]);
                check("R6 R7 sync_lost", sync_lost, x[0]);
            end
        end
    end

    // Monitor: every low phase must be quiet
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rst_n) begin
                check("R4 err_pulse low phase", err_pulse, 1'b0);
                check("R5 bit_pulse low phase", bit_pulse, 1'b0);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic b;
        // R1: reset with lock high and data high must keep outputs low
        rx_bit  = 1'b1;
        lock_in = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check("R1 err_pulse in reset", err_pulse, 1'b0);
        check("R1 bit_pulse in reset", bit_pulse, 1'b0);
        check("R1 sync_lost in reset", sync_lost, 1'b0);
        @(negedge clk);
        rst_n   = 1'b1;
        lock_in = 1'b0;

        // R2, R3: seed while unlocked, then a clean locked stream gives no error
        send_run(40, 1'b0, 0, 0);
        send_run(200, 1'b1, 0, 0);

        // R8, R4: isolated, paired and tripled flips while locked
        send_run(12, 1'b1, 10, 11);
        send_run(20, 1'b1, 5, 7);
        send_run(20, 1'b1, 3, 6);
        send_run(30, 1'b1, 0, 0);

        // R2: flips while unlocked are loaded but never reported; clean reseed
        send_run(20, 1'b0, 0, 20);
        send_run(20, 1'b0, 0, 0);
        send_run(100, 1'b1, 0, 0);

        // R6: a window with exactly 256 errors, then one with 257
        send_run(1, 1'b0, 0, 0);
        send_run(1024, 1'b1, 0, 256);
        send_run(1024, 1'b1, 100, 357);
        // R7: sticky across the window boundary, then cleared by loss of lock
        send_run(40, 1'b1, 0, 0);
        send_run(2, 1'b0, 0, 0);

        // R6: mis-seeded reference (all zeros) gives an error ratio near one half
        for (int i = 0; i < 15; i++) drive_bit(1'b0, 1'b0);
        send_run(1024, 1'b1, 0, 0);
        send_run(3, 1'b0, 0, 0);

        repeat (3) @(posedge clk);
        #2;
        if (exp_q.size() != 0) begin
            checks++;
            fails++;
            $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule